// File: doc/BRIEF.md
# Load/Store Address Generator

This block forms the memory address and the base-register update value for single-word load and store instructions. Each cycle it takes a 32-bit instruction word, the value read from the base register, the value read from the index register, the current carry flag and the address of the instruction itself. It decodes the addressing fields and produces the access address, the value to write back into the base register, and a strobe saying whether that writeback should happen.

The offset is either a 12-bit unsigned immediate or the index register shifted by an immediate amount. The offset is added to or subtracted from the base. A single adder serves both indexing forms. With pre-indexing the adjusted value is the access address, and it is written back only on request. With post-indexing the access goes to the untouched base, and the adjusted value is always written back. Encodings that ask for a register-specified shift are flagged as illegal so the enclosing core can raise a trap. All outputs are registered, so a result appears one clock after its inputs are sampled.

Top module: `lsag_top`

## Requirements
- R1: While `rst` is high at a clock edge, the registered outputs are cleared: address 0, writeback value 0, writeback strobe 0, illegal flag 0.
- R2: When instruction bit 25 is 0, the offset is instruction bits [11:0], zero-extended.
- R3: Instruction bit 23 set adds the offset to the base, and bit 23 clear subtracts it, wrapping modulo 2^32.
- R4: When bit 24 is 1 (pre-indexed), the address is the adjusted value and the writeback strobe equals bit 21.
- R5: When bit 24 is 0 (post-indexed), the address is the unmodified base and the writeback strobe is 1 whatever bit 21 holds.
- R6: For every legal encoding, the writeback value equals base plus or minus the offset.
- R7: When bit 25 is 1 and bit 4 is 0, the offset is the index value shifted by the amount in bits [11:7], with the kind selected by bits [6:5]. Code 0 is a left shift, where amount 0 leaves the value unchanged. Code 1 is a logical right shift, where amount 0 means a shift by 32 and gives 0.
- R8: Shift code 2 is an arithmetic right shift, where amount 0 fills all bits with the sign bit. Shift code 3 is a rotate right, where amount 0 means a one-bit rotate through carry: the result is `{carry_in, index[31:1]}`.
- R9: When bit 25 and bit 4 are both 1, the illegal flag is 1 and the writeback strobe is 0. Otherwise the illegal flag is 0.
- R10: When bits [19:16] equal 15, the base used is `inst_addr + 8` and `base_val` has no effect.
- R11: The outputs reflect the inputs present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Load/store instruction word |
| base_val | input | 32 | Value read from the base register |
| index_val | input | 32 | Value read from the index register |
| carry_in | input | 1 | Current carry flag, used by rotate-through-carry |
| inst_addr | input | 32 | Address of this instruction |
| addr_q | output | 32 | Registered access address |
| wb_val_q | output | 32 | Registered base writeback value |
| wb_en_q | output | 1 | Registered base writeback strobe |
| illegal_q | output | 1 | Registered illegal-encoding flag |

## Verification
The bench builds the block with its defaults: a 32-bit datapath, a program-counter look-ahead of 8, and register 15 as the program-counter index. Under these defaults, the zero-amount shift rules fall exactly at the 32-bit boundary: a logical right shift clears the value, and an arithmetic right shift fills it with the sign bit. They also allow the r15 base substitution to be checked against a base value that differs from the program-counter value. The vectors cover both indexing forms in both directions, all four shift kinds at zero and non-zero amounts, rotate through carry with each carry value, a borrow through zero, and the illegal register-shift encoding.

// File: rtl/lsag_pkg.sv
package lsag_pkg;

  typedef enum logic [1:0] {
    SHK_LSL = 2'd0,
    SHK_LSR = 2'd1,
    SHK_ASR = 2'd2,
    SHK_ROR = 2'd3
  } shift_kind_e;

  typedef struct packed {
    logic        reg_off;   // offset comes from the index register
    logic        pre;       // pre-indexed form
    logic        up;        // add offset when set
    logic        wb_req;    // writeback requested
    logic [3:0]  base_idx;  // base register number
    logic [4:0]  sh_amt;    // immediate shift amount
    shift_kind_e sh_kind;   // shift kind
    logic        sh_by_reg; // register-specified shift (not supported)
    logic [11:0] imm12;     // immediate offset
  } ls_fields_t;

  function automatic ls_fields_t decode_ls(input logic [31:0] iw);
    ls_fields_t f;
    f.reg_off   = iw[25];
    f.pre       = iw[24];
    f.up        = iw[23];
    f.wb_req    = iw[21];
    f.base_idx  = iw[19:16];
    f.sh_amt    = iw[11:7];
    f.sh_kind   = shift_kind_e'(iw[6:5]);
    f.sh_by_reg = iw[4];
    f.imm12     = iw[11:0];
    return f;
  endfunction

endpackage

// File: rtl/lsag_base_sel.sv
module lsag_base_sel #(
  parameter int W        = 32,
  parameter int PC_AHEAD = 8,
  parameter int PC_IDX   = 15
) (
  input  logic [3:0]   base_idx,
  input  logic [W-1:0] base_val,
  input  logic [W-1:0] inst_addr,
  output logic [W-1:0] base_eff
);
  localparam logic [3:0]   PC_SEL = 4'(PC_IDX);
  localparam logic [W-1:0] AHEAD  = W'(PC_AHEAD);

  always_comb begin
    if (base_idx == PC_SEL) base_eff = inst_addr + AHEAD;
    else                    base_eff = base_val;
  end
endmodule

// File: rtl/lsag_index_shift.sv
module lsag_index_shift
  import lsag_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] idx_val,
  input  logic [4:0]   amt,
  input  shift_kind_e  kind,
  input  logic         cin,
  output logic [W-1:0] shifted
);
  localparam int DW = 2 * W;

  logic [DW-1:0] doubled;
  logic [DW-1:0] rot_wide;

  assign doubled  = {idx_val, idx_val};
  assign rot_wide = doubled >> amt;

  always_comb begin
    unique case (kind)
      SHK_LSL: shifted = idx_val << amt;
      SHK_LSR: begin
        if (amt == 5'd0) shifted = '0;
        else             shifted = idx_val >> amt;
      end
      SHK_ASR: begin
        if (amt == 5'd0) shifted = {W{idx_val[W-1]}};
        else             shifted = W'($signed(idx_val) >>> amt);
      end
      SHK_ROR: begin
        if (amt == 5'd0) shifted = {cin, idx_val[W-1:1]};
        else             shifted = rot_wide[W-1:0];
      end
      default: shifted = idx_val;
    endcase
  end
endmodule

// File: rtl/lsag_offset_add.sv
module lsag_offset_add #(
  parameter int W = 32
) (
  input  logic [W-1:0] base_eff,
  input  logic [W-1:0] offset,
  input  logic         up,
  input  logic         pre,
  input  logic         wb_req,
  input  logic         illegal,
  output logic [W-1:0] addr,
  output logic [W-1:0] wb_val,
  output logic         wb_en
);
  logic [W-1:0] adjusted;

  always_comb begin
    adjusted = up ? (base_eff + offset) : (base_eff - offset);
    wb_val   = adjusted;
    addr     = pre ? adjusted : base_eff;
    if (illegal)  wb_en = 1'b0;
    else if (pre) wb_en = wb_req;
    else          wb_en = 1'b1;
  end
endmodule

// File: rtl/lsag_top.sv
module lsag_top
  import lsag_pkg::*;
#(
  parameter int W        = 32,
  parameter int IMM_W    = 12,
  parameter int PC_AHEAD = 8,
  parameter int PC_IDX   = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [31:0]  instr,
  input  logic [W-1:0] base_val,
  input  logic [W-1:0] index_val,
  input  logic         carry_in,
  input  logic [W-1:0] inst_addr,
  output logic [W-1:0] addr_q,
  output logic [W-1:0] wb_val_q,
  output logic         wb_en_q,
  output logic         illegal_q
);
  localparam int PAD_W = W - IMM_W;

  ls_fields_t   fld;
  logic [W-1:0] base_eff;
  logic [W-1:0] shifted;
  logic [W-1:0] offset;
  logic         illegal;
  logic [W-1:0] addr_d;
  logic [W-1:0] wb_val_d;
  logic         wb_en_d;

  assign fld     = decode_ls(instr);
  assign illegal = fld.reg_off & fld.sh_by_reg;

  lsag_base_sel #(
    .W(W), .PC_AHEAD(PC_AHEAD), .PC_IDX(PC_IDX)
  ) u_base (
    .base_idx (fld.base_idx),
    .base_val (base_val),
    .inst_addr(inst_addr),
    .base_eff (base_eff)
  );

  lsag_index_shift #(.W(W)) u_shift (
    .idx_val(index_val),
    .amt    (fld.sh_amt),
    .kind   (fld.sh_kind),
    .cin    (carry_in),
    .shifted(shifted)
  );

  always_comb begin
    if (fld.reg_off) offset = shifted;
    else             offset = {{PAD_W{1'b0}}, fld.imm12[IMM_W-1:0]};
  end

  lsag_offset_add #(.W(W)) u_add (
    .base_eff(base_eff),
    .offset  (offset),
    .up      (fld.up),
    .pre     (fld.pre),
    .wb_req  (fld.wb_req),
    .illegal (illegal),
    .addr    (addr_d),
    .wb_val  (wb_val_d),
    .wb_en   (wb_en_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q    <= '0;
      wb_val_q  <= '0;
      wb_en_q   <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      addr_q    <= addr_d;
      wb_val_q  <= wb_val_d;
      wb_en_q   <= wb_en_d;
      illegal_q <= illegal;
    end
  end
endmodule

// File: rtl/lsag_checker.sv
module lsag_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [31:0]  instr,
  input logic [W-1:0] base_val,
  input logic [W-1:0] addr_q,
  input logic [W-1:0] wb_val_q,
  input logic         wb_en_q,
  input logic         illegal_q
);
  logic legal_in;
  logic rst_seen;

  assign legal_in = !(instr[25] && instr[4]);

  always_ff @(posedge clk) begin
    rst_seen <= rst;
    if (rst_seen) begin
      AST_RESET_CLEARS: assert (addr_q == '0 && wb_val_q == '0 && !wb_en_q && !illegal_q); // R1
    end
  end

  AST_POST_ALWAYS_WRITES: assert property (@(posedge clk) disable iff (rst)
    (!instr[24] && legal_in) |=> wb_en_q); // R5

  AST_POST_ADDR_BASE: assert property (@(posedge clk) disable iff (rst)
    (!instr[24] && legal_in && instr[19:16] != 4'd15) |=> (addr_q == $past(base_val))); // R5

  AST_PRE_STROBE_W: assert property (@(posedge clk) disable iff (rst)
    (instr[24] && legal_in) |=> (wb_en_q == $past(instr[21]))); // R4

  AST_PRE_ADDR_WB: assert property (@(posedge clk) disable iff (rst)
    (instr[24] && legal_in) |=> (addr_q == wb_val_q)); // R4

  AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (illegal_q == $past(instr[25] && instr[4]))); // R9

  AST_ILLEGAL_NO_WB: assert property (@(posedge clk) disable iff (rst)
    illegal_q |-> !wb_en_q); // R9
endmodule

bind lsag_top lsag_checker #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .instr    (instr),
  .base_val (base_val),
  .addr_q   (addr_q),
  .wb_val_q (wb_val_q),
  .wb_en_q  (wb_en_q),
  .illegal_q(illegal_q)
);

// File: tb/sim_lsag_top.sv
module sim_lsag_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0;
  logic [31:0] base_val = '0;
  logic [31:0] index_val = '0;
  logic        carry_in = 1'b0;
  logic [31:0] inst_addr = '0;
  logic [31:0] addr_q;
  logic [31:0] wb_val_q;
  logic        wb_en_q;
  logic        illegal_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  lsag_top u0 (
    .clk(clk), .rst(rst), .instr(instr), .base_val(base_val),
    .index_val(index_val), .carry_in(carry_in), .inst_addr(inst_addr),
    .addr_q(addr_q), .wb_val_q(wb_val_q), .wb_en_q(wb_en_q), .illegal_q(illegal_q)
  );

  typedef struct packed {
    logic [23:0] tag;
    logic [31:0] iw;
    logic [31:0] base;
    logic [31:0] idx;
    logic        c;
    logic [31:0] pc;
    logic        chk_data;
    logic [31:0] e_addr;
    logic [31:0] e_wb;
    logic        e_en;
    logic        e_ill;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{"R2 ", 32'hE5910010, 32'h1000, 32'h0,        1'b0, 32'h0,   1'b1, 32'h00001010, 32'h00001010, 1'b0, 1'b0},
    '{"R3 ", 32'hE5310004, 32'h1000, 32'h0,        1'b0, 32'h0,   1'b1, 32'h00000FFC, 32'h00000FFC, 1'b1, 1'b0},
    '{"R5 ", 32'hE4910FFF, 32'h1000, 32'h0,        1'b0, 32'h0,   1'b1, 32'h00001000, 32'h00001FFF, 1'b1, 1'b0},
    '{"R5 ", 32'hE4310020, 32'h1000, 32'h0,        1'b0, 32'h0,   1'b1, 32'h00001000, 32'h00000FE0, 1'b1, 1'b0},
    '{"R4 ", 32'hE7B10102, 32'h1000, 32'h10,       1'b0, 32'h0,   1'b1, 32'h00001040, 32'h00001040, 1'b1, 1'b0},
    '{"R7 ", 32'hE7910022, 32'h1000, 32'h80000000, 1'b0, 32'h0,   1'b1, 32'h00001000, 32'h00001000, 1'b0, 1'b0},
    '{"R6 ", 32'hE6110222, 32'h1000, 32'h100,      1'b0, 32'h0,   1'b1, 32'h00001000, 32'h00000FF0, 1'b1, 1'b0},
    '{"R8 ", 32'hE7110042, 32'h1000, 32'h80000000, 1'b0, 32'h0,   1'b1, 32'h00001001, 32'h00001001, 1'b0, 1'b0},
    '{"R8 ", 32'hE7910242, 32'h1000, 32'h80000000, 1'b0, 32'h0,   1'b1, 32'hF8001000, 32'hF8001000, 1'b0, 1'b0},
    '{"R8 ", 32'hE7910462, 32'h1000, 32'hAB,       1'b0, 32'h0,   1'b1, 32'hAB001000, 32'hAB001000, 1'b0, 1'b0},
    '{"R8 ", 32'hE7910062, 32'h1000, 32'h3,        1'b1, 32'h0,   1'b1, 32'h80001001, 32'h80001001, 1'b0, 1'b0},
    '{"R8 ", 32'hE7910062, 32'h1000, 32'h3,        1'b0, 32'h0,   1'b1, 32'h00001001, 32'h00001001, 1'b0, 1'b0},
    '{"R9 ", 32'hE7B10012, 32'h1000, 32'h4,        1'b0, 32'h0,   1'b0, 32'h0,        32'h0,        1'b0, 1'b1},
    '{"R10", 32'hE59F0004, 32'hDEAD, 32'h0,        1'b0, 32'h200, 1'b1, 32'h0000020C, 32'h0000020C, 1'b0, 1'b0},
    '{"R7 ", 32'hE6910002, 32'h1000, 32'h55,       1'b0, 32'h0,   1'b1, 32'h00001000, 32'h00001055, 1'b1, 1'b0},
    '{"R7 ", 32'hE7910FA2, 32'h1000, 32'h80000000, 1'b0, 32'h0,   1'b1, 32'h00001001, 32'h00001001, 1'b0, 1'b0},
    '{"R3 ", 32'hE5110001, 32'h0,    32'h0,        1'b0, 32'h0,   1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b0}
  };

  task automatic check32(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    instr = v.iw; base_val = v.base; index_val = v.idx;
    carry_in = v.c; inst_addr = v.pc;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: outputs cleared under reset
    drive(TBL[1]);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check32("R1", "addr", addr_q, 32'h0);
    check32("R1", "wb_val", wb_val_q, 32'h0);
    check32("R1", "wb_en", {31'h0, wb_en_q}, 32'h0);
    check32("R1", "illegal", {31'h0, illegal_q}, 32'h0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      @(posedge clk);
      #1;
      if (TBL[i].chk_data) begin
        check32(string'(TBL[i].tag), "addr", addr_q, TBL[i].e_addr);
        check32(string'(TBL[i].tag), "wb_val", wb_val_q, TBL[i].e_wb);
      end
      check32(string'(TBL[i].tag), "wb_en", {31'h0, wb_en_q}, {31'h0, TBL[i].e_en});
      check32(string'(TBL[i].tag), "illegal", {31'h0, illegal_q}, {31'h0, TBL[i].e_ill});
    end

    // R11: changing inputs after an edge leaves outputs until the next edge
    drive(TBL[0]);
    @(posedge clk);
    #1;
    instr = TBL[2].iw;
    #3;
    check32("R11", "addr held", addr_q, 32'h00001010);
    check32("R11", "wb_en held", {31'h0, wb_en_q}, 32'h0);
    @(posedge clk);
    #1;
    check32("R11", "addr next", addr_q, 32'h00001000);
    check32("R11", "wb_en next", {31'h0, wb_en_q}, 32'h1);

    // R10: base_val has no effect when base index is 15
    drive(TBL[13]);
    base_val = 32'h7777_0000;
    @(posedge clk);
    #1;
    check32("R10", "addr r15", addr_q, 32'h0000020C);

    // R1: mid-run reset clears a nonzero state
    drive(TBL[12]);
    @(posedge clk);
    #1;
    check32("R9", "illegal set", {31'h0, illegal_q}, 32'h1);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check32("R1", "illegal cleared", {31'h0, illegal_q}, 32'h0);
    check32("R1", "addr cleared", addr_q, 32'h0);
    @(negedge clk);
    rst = 1'b0;

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule